// File: doc/BRIEF.md
# SD/eMMC PHY Timing Mode Sequencer

This block reprograms an SD/eMMC PHY when the bus clock or timing mode changes. A controller gives it a timing mode, a pad drive-strength code, the new bus clock in MHz and a poll limit, and then pulses start. The sequencer writes the PHY registers in a fixed order through a simple request/done register port. For the faster modes it also does a read-modify-write of the pad control register. It then clears the DLL and, outside legacy mode, enables the DLL again with a frequency select and polls until the DLL is ready.

The block ends each run with a one-cycle `done_o` pulse or, when the DLL fails to lock in time, a one-cycle `err_o` pulse. If the requested clock equals the clock of the last accepted request, the sequencer finishes at once and touches no PHY register. Requests are taken only while the block is idle.

Top module: `phy_mode_seq`

## Requirements
- R1: The first write of every run goes to offset 0x11 with the mode code. Mode input encoding is 0 legacy, 1 high-speed, 2 HS200, 3 DDR50, 4 HS400, 5 enhanced strobe. The codes written are legacy 0x04, DDR50 0x08, HS400 0x02, enhanced strobe 0x01, and 0x00 for high-speed and HS200.
- R2: The output tap is written to 0x0D and the input tap to 0x0C, each encoded as (tap<<1)|1. The (output, input) taps are high-speed (3,2), HS200 (2,0), DDR50 (1,0), HS400 (1,0xA) and enhanced strobe (1,0). Legacy writes 0 to both registers, and HS200 writes 0 to 0x0C.
- R3: Only HS400 and HS200 read offset 0x01 and write back the value read ORed with the drive code shifted left by 2. Other modes never access 0x01.
- R4: Every mode except legacy writes 0x08 to offset 0x12. Legacy never accesses 0x12.
- R5: Offset 0x00 is written with 0x00. Outside legacy mode it is then written with (freqsel<<5)|0x08, where freqsel is 0 for 200 MHz, 2 for 100 MHz, 1 for 50 MHz and 0 for any other clock. Offset 0x00 is then read until bit 4 is set, and that read ends the run with `done_o`.
- R6: The writes occur in this order: mode, pad (when present), output tap, input tap, trim (when present), DLL clear, DLL enable (when present).
- R7: A start whose clock equals the clock of the last accepted request gives `done_o` with no PHY access. The first request after reset always runs.
- R8: If bit 4 is still clear on a poll read once at least `poll_limit_i` cycles have passed in the poll step, the run ends with `err_o` and no `done_o`.
- R9: `busy_o` is high from the cycle after an accepted start until the run ends. A start while busy is ignored and does not update the remembered clock.
- R10: Mode codes 6 and 7 finish with `done_o` and no PHY access, but the clock is still remembered.
- R11: After reset `busy_o`, `done_o`, `err_o` and `phy_req_o` are low.
- R12: `phy_req_o` stays high, with stable offset and write data, until `phy_done_i`. `done_o` and `err_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse |
| mode_i | input | 3 | Timing mode code |
| drv_i | input | DRV_W | Pad drive-strength code |
| clk_mhz_i | input | FREQ_W | Requested bus clock in MHz |
| poll_limit_i | input | TMO_W | DLL ready poll limit in cycles |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Run finished successfully (pulse) |
| err_o | output | 1 | DLL ready timeout (pulse) |
| phy_req_o | output | 1 | PHY register access request |
| phy_we_o | output | 1 | Access is a write |
| phy_addr_o | output | 8 | PHY register offset |
| phy_wdata_o | output | 8 | PHY write data |
| phy_rdata_i | input | 8 | PHY read data, valid with done |
| phy_done_i | input | 1 | PHY access complete |

## Verification
The bench drives every mode and compares the full list of PHY writes with a list built from the requirements. A design that got the HS200 input-tap override wrong would write 0x01 to 0x0C instead of 0x00. A design that mapped the frequency selects wrongly would put 0x28 and 0x48 in the wrong runs. A design that did not skip the steps for legacy mode would write the trim or the DLL enable.

Two tests target the start logic. One repeats a clock to check that no PHY access occurs. The other pulses start in the middle of a run to check that the extra request neither disturbs the sequence nor overwrites the remembered clock.

A PHY model that never reports ready forces the timeout path, where an `err_o` pulse must replace `done_o`.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;
  localparam int unsigned REG_W = 8;

  localparam logic [2:0] TM_LEGACY = 3'd0;
  localparam logic [2:0] TM_HS     = 3'd1;
  localparam logic [2:0] TM_HS200  = 3'd2;
  localparam logic [2:0] TM_DDR    = 3'd3;
  localparam logic [2:0] TM_HS400  = 3'd4;
  localparam logic [2:0] TM_ENH    = 3'd5;

  localparam logic [REG_W-1:0] OFS_DLL  = 8'h00;
  localparam logic [REG_W-1:0] OFS_PAD  = 8'h01;
  localparam logic [REG_W-1:0] OFS_ITAP = 8'h0C;
  localparam logic [REG_W-1:0] OFS_OTAP = 8'h0D;
  localparam logic [REG_W-1:0] OFS_MODE = 8'h11;
  localparam logic [REG_W-1:0] OFS_TRIM = 8'h12;
  localparam logic [REG_W-1:0] TRIM_VAL = 8'h08;
  localparam int unsigned      DLL_EN_BIT  = 3;
  localparam int unsigned      DLL_RDY_BIT = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_MODE, ST_PAD_RD, ST_PAD_WR, ST_OTAP, ST_ITAP,
    ST_TRIM, ST_DLL_CLR, ST_DLL_EN, ST_POLL, ST_OK, ST_ERR
  } step_e;

  function automatic logic mode_valid(input logic [2:0] m);
    return m <= TM_ENH;
  endfunction

  function automatic step_e next_step(input step_e cur, input logic [2:0] m);
    logic legacy, pad;
    legacy = (m == TM_LEGACY);
    pad    = (m == TM_HS400) || (m == TM_HS200);
    case (cur)
      ST_MODE:    return pad ? ST_PAD_RD : ST_OTAP;
      ST_PAD_RD:  return ST_PAD_WR;
      ST_PAD_WR:  return ST_OTAP;
      ST_OTAP:    return ST_ITAP;
      ST_ITAP:    return legacy ? ST_DLL_CLR : ST_TRIM;
      ST_TRIM:    return ST_DLL_CLR;
      ST_DLL_CLR: return legacy ? ST_OK : ST_DLL_EN;
      ST_DLL_EN:  return ST_POLL;
      default:    return ST_IDLE;
    endcase
  endfunction
endpackage

// File: rtl/phy_seq_encode.sv
module phy_seq_encode
  import phy_seq_pkg::*;
#(
  parameter int unsigned DRV_W  = 2,
  parameter int unsigned FREQ_W = 8
) (
  input  logic [2:0]        mode_i,
  input  logic [DRV_W-1:0]  drv_i,
  input  logic [FREQ_W-1:0] clk_mhz_i,
  input  logic [REG_W-1:0]  pad_rd_i,
  output logic [REG_W-1:0]  mode_val_o,
  output logic [REG_W-1:0]  otap_val_o,
  output logic [REG_W-1:0]  itap_val_o,
  output logic [REG_W-1:0]  pad_val_o,
  output logic [REG_W-1:0]  dll_en_val_o
);
  localparam int unsigned PAD_SH = 2;
  localparam int unsigned FS_SH  = 5;

  logic [3:0] otap, itap;
  logic [1:0] fsel;

  always_comb begin
    mode_val_o = '0;
    otap = 4'd0;
    itap = 4'd0;
    case (mode_i)
      TM_HS:    begin otap = 4'd3; itap = 4'd2; end
      TM_HS200: begin otap = 4'd2; itap = 4'd0; end
      TM_DDR:   begin mode_val_o = 8'h08; otap = 4'd1; itap = 4'd0; end
      TM_HS400: begin mode_val_o = 8'h02; otap = 4'd1; itap = 4'hA; end
      TM_ENH:   begin mode_val_o = 8'h01; otap = 4'd1; itap = 4'd0; end
      TM_LEGACY: mode_val_o = 8'h04;
      default:  ;
    endcase
  end

  always_comb begin
    otap_val_o = (mode_i == TM_LEGACY) ? '0 : {3'b0, otap, 1'b1};
    itap_val_o = (mode_i == TM_LEGACY || mode_i == TM_HS200) ? '0 : {3'b0, itap, 1'b1};
  end

  always_comb begin
    if (clk_mhz_i == FREQ_W'(100))     fsel = 2'd2;
    else if (clk_mhz_i == FREQ_W'(50)) fsel = 2'd1;
    else                               fsel = 2'd0;
    dll_en_val_o = REG_W'(fsel) << FS_SH;
    dll_en_val_o[DLL_EN_BIT] = 1'b1;
  end

  assign pad_val_o = pad_rd_i | (REG_W'(drv_i) << PAD_SH);
endmodule

// File: rtl/phy_seq_timer.sv
module phy_seq_timer #(
  parameter int unsigned TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             expired_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i)           cnt_q <= '0;
    else if (cnt_q != '1)      cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = cnt_q >= limit_i;

  AST_TMR_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0); // R8
endmodule

// File: rtl/phy_seq_clk_track.sv
module phy_seq_clk_track #(
  parameter int unsigned FREQ_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic [FREQ_W-1:0] clk_mhz_i,
  output logic              same_o
);
  logic [FREQ_W-1:0] last_q;
  logic              vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      vld_q  <= 1'b0;
    end else if (accept_i) begin
      last_q <= clk_mhz_i;
      vld_q  <= 1'b1;
    end
  end

  assign same_o = vld_q && (last_q == clk_mhz_i);
endmodule

// File: rtl/phy_mode_seq.sv
module phy_mode_seq
  import phy_seq_pkg::*;
#(
  parameter int unsigned DRV_W  = 2,
  parameter int unsigned FREQ_W = 8,
  parameter int unsigned TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [2:0]        mode_i,
  input  logic [DRV_W-1:0]  drv_i,
  input  logic [FREQ_W-1:0] clk_mhz_i,
  input  logic [TMO_W-1:0]  poll_limit_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              phy_req_o,
  output logic              phy_we_o,
  output logic [7:0]        phy_addr_o,
  output logic [7:0]        phy_wdata_o,
  input  logic [7:0]        phy_rdata_i,
  input  logic              phy_done_i
);
  step_e             state_q;
  logic [2:0]        mode_q;
  logic [DRV_W-1:0]  drv_q;
  logic [FREQ_W-1:0] clk_q;
  logic [TMO_W-1:0]  lim_q;
  logic [REG_W-1:0]  pad_q;
  logic              accept, same_clk, tmo_hit;
  logic [REG_W-1:0]  mode_val, otap_val, itap_val, pad_val, dll_en_val;

  assign accept = start_i && (state_q == ST_IDLE);

  phy_seq_clk_track #(.FREQ_W(FREQ_W)) u_clk_track (
    .clk_i, .rst_ni, .accept_i(accept), .clk_mhz_i, .same_o(same_clk)
  );

  phy_seq_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i, .rst_ni, .run_i(state_q == ST_POLL), .limit_i(lim_q), .expired_o(tmo_hit)
  );

  phy_seq_encode #(.DRV_W(DRV_W), .FREQ_W(FREQ_W)) u_encode (
    .mode_i(mode_q), .drv_i(drv_q), .clk_mhz_i(clk_q), .pad_rd_i(pad_q),
    .mode_val_o(mode_val), .otap_val_o(otap_val), .itap_val_o(itap_val),
    .pad_val_o(pad_val), .dll_en_val_o(dll_en_val)
  );

  always_comb begin
    phy_req_o   = 1'b1;
    phy_we_o    = 1'b1;
    phy_addr_o  = '0;
    phy_wdata_o = '0;
    case (state_q)
      ST_MODE:    begin phy_addr_o = OFS_MODE; phy_wdata_o = mode_val; end
      ST_PAD_RD:  begin phy_addr_o = OFS_PAD;  phy_we_o = 1'b0; end
      ST_PAD_WR:  begin phy_addr_o = OFS_PAD;  phy_wdata_o = pad_val; end
      ST_OTAP:    begin phy_addr_o = OFS_OTAP; phy_wdata_o = otap_val; end
      ST_ITAP:    begin phy_addr_o = OFS_ITAP; phy_wdata_o = itap_val; end
      ST_TRIM:    begin phy_addr_o = OFS_TRIM; phy_wdata_o = TRIM_VAL; end
      ST_DLL_CLR: phy_addr_o = OFS_DLL;
      ST_DLL_EN:  begin phy_addr_o = OFS_DLL;  phy_wdata_o = dll_en_val; end
      ST_POLL:    begin phy_addr_o = OFS_DLL;  phy_we_o = 1'b0; end
      default:    begin phy_req_o = 1'b0; phy_we_o = 1'b0; end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= '0;
      drv_q   <= '0;
      clk_q   <= '0;
      lim_q   <= '0;
      pad_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          mode_q  <= mode_i;
          drv_q   <= drv_i;
          clk_q   <= clk_mhz_i;
          lim_q   <= poll_limit_i;
          state_q <= (same_clk || !mode_valid(mode_i)) ? ST_OK : ST_MODE;
        end
        ST_OK, ST_ERR: state_q <= ST_IDLE;
        ST_POLL: if (phy_done_i) begin
          if (phy_rdata_i[DLL_RDY_BIT]) state_q <= ST_OK;
          else if (tmo_hit)             state_q <= ST_ERR;
        end
        default: if (phy_done_i) begin
          if (state_q == ST_PAD_RD) pad_q <= phy_rdata_i;
          state_q <= next_step(state_q, mode_q);
        end
      endcase
    end
  end

  assign busy_o = state_q != ST_IDLE;
  assign done_o = state_q == ST_OK;
  assign err_o  = state_q == ST_ERR;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && !phy_done_i |=> phy_req_o && $stable(phy_addr_o) && $stable(phy_wdata_o)); // R12
  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o)); // R12
  AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !phy_req_o); // R11
  AST_LEGACY_NO_TRIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && mode_q == TM_LEGACY |-> phy_addr_o != OFS_TRIM); // R4
  AST_PAD_MODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phy_req_o && phy_addr_o == OFS_PAD |-> mode_q == TM_HS400 || mode_q == TM_HS200); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o); // R9
endmodule

// File: tb/phy_mode_seq_tb.sv
module phy_mode_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  mode = '0;
  logic [1:0]  drv = '0;
  logic [7:0]  mhz = '0;
  logic [15:0] lim = 16'd200;
  logic        busy, done, err, req, we, phy_done;
  logic [7:0]  addr, wdata, rdata;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  logic [7:0] log_a [32];
  logic [7:0] log_d [32];
  int         nlog = 0;
  bit         dll_en = 0;
  bit         ready_ok = 1;
  int         rd_cnt = 0;
  logic [15:0] exp_w [8];

  always #10 clk = ~clk;

  phy_mode_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode), .drv_i(drv),
    .clk_mhz_i(mhz), .poll_limit_i(lim), .busy_o(busy), .done_o(done), .err_o(err),
    .phy_req_o(req), .phy_we_o(we), .phy_addr_o(addr), .phy_wdata_o(wdata),
    .phy_rdata_i(rdata), .phy_done_i(phy_done)
  );

  // PHY model: one-cycle response, pad register reads 0x42
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_done <= 1'b0;
      rdata    <= '0;
    end else begin
      phy_done <= req && !phy_done;
      if (req && !phy_done) begin
        if (we) begin
          if (nlog < 32) begin log_a[nlog] = addr; log_d[nlog] = wdata; end
          nlog++;
          if (addr == 8'h00) begin dll_en = wdata[3]; rd_cnt = 0; end
        end else if (addr == 8'h01) begin
          rdata <= 8'h42;
        end else if (addr == 8'h00) begin
          rd_cnt++;
          rdata <= (dll_en && ready_ok && rd_cnt >= 3) ? 8'h18 : 8'h08;
        end else begin
          rdata <= 8'h00;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp_v);
    end
  endtask

  task automatic run(input logic [2:0] m, input logic [1:0] d, input logic [7:0] f);
    @(negedge clk);
    nlog = 0;
    mode = m; drv = d; mhz = f; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_err);
    got_done = 0; got_err = 0;
    for (int i = 0; i < 3000; i++) begin
      if (done || err) begin got_done = done; got_err = err; break; end
      @(negedge clk);
    end
  endtask

  task automatic expect_writes(input string tag, input int n);
    check({tag, " write count"}, nlog, n);
    for (int i = 0; i < n && i < nlog; i++)
      check($sformatf("%s write %0d", tag, i), {log_a[i], log_d[i]}, exp_w[i]);
  endtask

  task automatic t_reset;
    check("R11 busy", busy, 0);
    check("R11 done", done, 0);
    check("R11 err", err, 0);
    check("R11 req", req, 0);
  endtask

  task automatic t_hs400;
    bit d, e;
    run(3'd4, 2'd2, 8'd200);
    check("R9 busy after start", busy, 1);
    wait_end(d, e);
    check("R5 hs400 done", d, 1);
    check("R12 hs400 no err", e, 0);
    exp_w[0] = 16'h1102; exp_w[1] = 16'h014A; exp_w[2] = 16'h0D03; exp_w[3] = 16'h0C15;
    exp_w[4] = 16'h1208; exp_w[5] = 16'h0000; exp_w[6] = 16'h0008;
    expect_writes("R1 R2 R3 R4 R6 hs400", 7);
  endtask

  task automatic t_legacy;
    bit d, e;
    run(3'd0, 2'd3, 8'd25);
    wait_end(d, e);
    check("R6 legacy done", d, 1);
    exp_w[0] = 16'h1104; exp_w[1] = 16'h0D00; exp_w[2] = 16'h0C00; exp_w[3] = 16'h0000;
    expect_writes("R2 R4 R5 legacy", 4);
  endtask

  task automatic t_same_clk;
    bit d, e;
    run(3'd1, 2'd0, 8'd25);
    wait_end(d, e);
    check("R7 same clock done", d, 1);
    check("R7 same clock no access", nlog, 0);
  endtask

  task automatic t_hs200;
    bit d, e;
    run(3'd2, 2'd1, 8'd100);
    wait_end(d, e);
    check("R5 hs200 done", d, 1);
    exp_w[0] = 16'h1100; exp_w[1] = 16'h0146; exp_w[2] = 16'h0D05; exp_w[3] = 16'h0C00;
    exp_w[4] = 16'h1208; exp_w[5] = 16'h0000; exp_w[6] = 16'h0048;
    expect_writes("R2 R3 R5 hs200", 7);
  endtask

  task automatic t_hs;
    bit d, e;
    run(3'd1, 2'd3, 8'd50);
    wait_end(d, e);
    check("R5 hs done", d, 1);
    exp_w[0] = 16'h1100; exp_w[1] = 16'h0D07; exp_w[2] = 16'h0C05; exp_w[3] = 16'h1208;
    exp_w[4] = 16'h0000; exp_w[5] = 16'h0028;
    expect_writes("R1 R2 R3 R5 hs", 6);
  endtask

  task automatic t_ddr;
    bit d, e;
    run(3'd3, 2'd0, 8'd200);
    wait_end(d, e);
    check("R5 ddr done", d, 1);
    exp_w[0] = 16'h1108; exp_w[1] = 16'h0D03; exp_w[2] = 16'h0C01; exp_w[3] = 16'h1208;
    exp_w[4] = 16'h0000; exp_w[5] = 16'h0008;
    expect_writes("R1 R2 ddr", 6);
  endtask

  task automatic t_enh;
    bit d, e;
    run(3'd5, 2'd0, 8'd52);
    wait_end(d, e);
    check("R5 enh done", d, 1);
    exp_w[0] = 16'h1101; exp_w[1] = 16'h0D03; exp_w[2] = 16'h0C01; exp_w[3] = 16'h1208;
    exp_w[4] = 16'h0000; exp_w[5] = 16'h0008;
    expect_writes("R1 R5 enh", 6);
  endtask

  task automatic t_timeout;
    bit d, e;
    ready_ok = 0;
    lim = 16'd20;
    run(3'd3, 2'd0, 8'd100);
    wait_end(d, e);
    check("R8 timeout err", e, 1);
    check("R8 timeout no done", d, 0);
    check("R8 writes before poll", nlog, 6);
    @(negedge clk);
    check("R8 idle after err", busy, 0);
    ready_ok = 1;
    lim = 16'd200;
  endtask

  task automatic t_busy_start;
    bit d, e;
    run(3'd2, 2'd1, 8'd150);
    repeat (4) @(negedge clk);
    mode = 3'd0; mhz = 8'd25; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 still busy", busy, 1);
    wait_end(d, e);
    check("R9 done", d, 1);
    exp_w[0] = 16'h1100; exp_w[1] = 16'h0146; exp_w[2] = 16'h0D05; exp_w[3] = 16'h0C00;
    exp_w[4] = 16'h1208; exp_w[5] = 16'h0000; exp_w[6] = 16'h0008;
    expect_writes("R9 busy start ignored", 7);
    run(3'd2, 2'd1, 8'd150);
    wait_end(d, e);
    check("R9 clock kept from accepted run", nlog, 0);
  endtask

  task automatic t_invalid;
    bit d, e;
    run(3'd6, 2'd0, 8'd77);
    wait_end(d, e);
    check("R10 invalid done", d, 1);
    check("R10 invalid no access", nlog, 0);
    run(3'd1, 2'd0, 8'd77);
    wait_end(d, e);
    check("R10 invalid clock remembered", nlog, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hs400();
    t_legacy();
    t_same_clk();
    t_hs200();
    t_hs();
    t_ddr();
    t_enh();
    t_timeout();
    t_busy_start();
    t_invalid();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule